// File: doc/BRIEF.md
# Accumulator with Link Bit

This block holds a processor's working register together with a one-bit link flag that catches the carry and the bits shifted out. The arithmetic and logic network sits in front of the register. Every new accumulator value passes through that network, including plain loads. A controller asserts one operation strobe per cycle. The block combines the current accumulator with a data operand or an input character, and the result is stored on the next clock edge.

The accumulator value is always visible on its output, so a shared bus can read it. A register on the far side of that bus can therefore trade contents with the accumulator on a single edge. Three combinational status flags support conditional skip decisions: the sign bit, accumulator-equals-zero and link-equals-zero.

Top module: `acc_link_unit`

## Requirements
- R1: An active-low reset, asserted at any time, forces the accumulator and the link bit to zero.
- R2: The AND strobe (op_i bit 0) replaces the accumulator with its bitwise AND with dr_i and leaves the link bit unchanged.
- R3: The ADD strobe (op_i bit 1) replaces the accumulator with the sum of the accumulator and dr_i, modulo 2^16. The link bit takes the carry out of the top bit.
- R4: The rotate-right strobe (op_i bit 5) turns the 17-bit ring of link and accumulator one place right. The old link enters bit 15, and the old bit 0 becomes the link.
- R5: The rotate-left strobe (op_i bit 6) turns the ring one place left. The old link enters bit 0, and the old bit 15 becomes the link.
- R6: The input strobe (op_i bit 3) writes inpr_i into accumulator bits 7..0 and clears bits 15..8. The link bit is unchanged.
- R7: The load strobe (op_i bit 2) copies dr_i into the accumulator. The complement strobe (op_i bit 4) inverts every accumulator bit. The increment strobe (op_i bit 7) adds one and wraps 0xFFFF to 0x0000. None of the three changes the link bit, and ac_o shows the old value until the edge.
- R8: The clear-link strobe (op_i bit 9) forces the link bit to 0. The complement-link strobe (op_i bit 10) inverts it, with clear-link winning when both are set. Neither strobe changes the accumulator.
- R9: The clear-accumulator strobe (op_i bit 8) zeroes the accumulator. When several accumulator strobes are set together, clear wins over the loading strobes (bits 0 to 6), and those win over increment.
- R10: When no strobe is set, the accumulator and the link bit hold their values whatever dr_i and inpr_i carry.
- R11: sign_o equals accumulator bit 15, ac_zero_o is 1 exactly when the accumulator is zero, and e_zero_o is 1 exactly when the link bit is 0. All three follow the registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_i | input | 11 | One-hot operation strobes, bit map as in R2 to R9 |
| dr_i | input | 16 | Data operand |
| inpr_i | input | 8 | Input character |
| ac_o | output | 16 | Accumulator value |
| e_o | output | 1 | Link bit |
| sign_o | output | 1 | Accumulator sign bit |
| ac_zero_o | output | 1 | Accumulator equals zero |
| e_zero_o | output | 1 | Link bit equals zero |

## Verification
The bench builds the block with its default 16-bit accumulator and 8-bit input character. That setting places the carry out of bit 15 within reach, through sums that overflow to exactly zero as well as sums that stop just short. It also exercises the upper byte that the input strobe must clear, and a full 17-bit ring for the rotations. Strobes are combined on purpose to show the clear, load and increment priority and the link-bit priority. A reset in the middle of the run shows that it acts without waiting for a clock edge.

// File: rtl/acc_pkg.sv
package acc_pkg;
  // Strobe positions inside the one-hot operation vector.
  localparam int OP_AND  = 0;
  localparam int OP_ADD  = 1;
  localparam int OP_LDDR = 2;
  localparam int OP_INP  = 3;
  localparam int OP_CMA  = 4;
  localparam int OP_SHR  = 5;
  localparam int OP_SHL  = 6;
  localparam int OP_INC  = 7;
  localparam int OP_CLA  = 8;
  localparam int OP_CLE  = 9;
  localparam int OP_CME  = 10;
  localparam int OP_W    = 11;

  typedef logic [OP_W-1:0] op_vec_t;

  // Accumulator source chosen for this cycle.
  typedef enum logic [3:0] {
    AS_HOLD, AS_CLR, AS_AND, AS_ADD, AS_LDDR,
    AS_INP, AS_CMA, AS_SHR, AS_SHL, AS_INC
  } ac_sel_e;

  // Link-bit source chosen for this cycle.
  typedef enum logic [2:0] {
    ES_HOLD, ES_CLR, ES_CMP, ES_CARRY, ES_LSB, ES_MSB
  } e_sel_e;
endpackage

// File: rtl/acc_opsel.sv
module acc_opsel
  import acc_pkg::*;
(
  input  op_vec_t op,
  output ac_sel_e ac_sel,
  output e_sel_e  e_sel
);
  // Accumulator priority: clear, then the loading group, then increment.
  always_comb begin
    ac_sel = AS_HOLD;
    if (op[OP_CLA])       ac_sel = AS_CLR;
    else if (op[OP_AND])  ac_sel = AS_AND;
    else if (op[OP_ADD])  ac_sel = AS_ADD;
    else if (op[OP_LDDR]) ac_sel = AS_LDDR;
    else if (op[OP_INP])  ac_sel = AS_INP;
    else if (op[OP_CMA])  ac_sel = AS_CMA;
    else if (op[OP_SHR])  ac_sel = AS_SHR;
    else if (op[OP_SHL])  ac_sel = AS_SHL;
    else if (op[OP_INC])  ac_sel = AS_INC;
  end

  // Explicit link strobes first, then whatever the chosen AC operation feeds out.
  always_comb begin
    e_sel = ES_HOLD;
    if (op[OP_CLE])              e_sel = ES_CLR;
    else if (op[OP_CME])         e_sel = ES_CMP;
    else if (ac_sel == AS_ADD)   e_sel = ES_CARRY;
    else if (ac_sel == AS_SHR)   e_sel = ES_LSB;
    else if (ac_sel == AS_SHL)   e_sel = ES_MSB;
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 8
) (
  input  ac_sel_e         ac_sel,
  input  e_sel_e          e_sel,
  input  logic [DW-1:0]   ac,
  input  logic            e,
  input  logic [DW-1:0]   dr,
  input  logic [IW-1:0]   inpr,
  output logic [DW-1:0]   ac_nxt,
  output logic            ac_en,
  output logic            e_nxt,
  output logic            e_en
);
  localparam int PADW = DW - IW;
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW:0] sum;
  assign sum = {1'b0, ac} + {1'b0, dr};

  always_comb begin
    ac_en  = (ac_sel != AS_HOLD);
    ac_nxt = ac;
    unique case (ac_sel)
      AS_CLR:  ac_nxt = '0;
      AS_AND:  ac_nxt = ac & dr;
      AS_ADD:  ac_nxt = sum[DW-1:0];
      AS_LDDR: ac_nxt = dr;
      AS_INP:  ac_nxt = {{PADW{1'b0}}, inpr};
      AS_CMA:  ac_nxt = ~ac;
      AS_SHR:  ac_nxt = {e, ac[DW-1:1]};
      AS_SHL:  ac_nxt = {ac[DW-2:0], e};
      AS_INC:  ac_nxt = ac + ONE;
      default: ac_nxt = ac;
    endcase
  end

  always_comb begin
    e_en  = (e_sel != ES_HOLD);
    e_nxt = e;
    unique case (e_sel)
      ES_CLR:   e_nxt = 1'b0;
      ES_CMP:   e_nxt = ~e;
      ES_CARRY: e_nxt = sum[DW];
      ES_LSB:   e_nxt = ac[0];
      ES_MSB:   e_nxt = ac[DW-1];
      default:  e_nxt = e;
    endcase
  end
endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] ac,
  input  logic          e,
  output logic          sign,
  output logic          ac_zero,
  output logic          e_zero
);
  assign sign    = ac[DW-1];
  assign ac_zero = ~|ac;
  assign e_zero  = ~e;
endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   dr_i,
  input  logic [IW-1:0]   inpr_i,
  output logic [DW-1:0]   ac_o,
  output logic            e_o,
  output logic            sign_o,
  output logic            ac_zero_o,
  output logic            e_zero_o
);
  ac_sel_e       ac_sel;
  e_sel_e        e_sel;
  logic [DW-1:0] ac_q, ac_nxt;
  logic          e_q, e_nxt;
  logic          ac_en, e_en;

  acc_opsel u_opsel (
    .op     (op_i),
    .ac_sel (ac_sel),
    .e_sel  (e_sel)
  );

  acc_datapath #(.DW(DW), .IW(IW)) u_dp (
    .ac_sel (ac_sel),
    .e_sel  (e_sel),
    .ac     (ac_q),
    .e      (e_q),
    .dr     (dr_i),
    .inpr   (inpr_i),
    .ac_nxt (ac_nxt),
    .ac_en  (ac_en),
    .e_nxt  (e_nxt),
    .e_en   (e_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ac_q <= '0;
    else if (ac_en) ac_q <= ac_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    e_q <= 1'b0;
    else if (e_en) e_q <= e_nxt;
  end

  acc_flags #(.DW(DW)) u_flags (
    .ac      (ac_q),
    .e       (e_q),
    .sign    (sign_o),
    .ac_zero (ac_zero_o),
    .e_zero  (e_zero_o)
  );

  assign ac_o = ac_q;
  assign e_o  = e_q;
endmodule

// File: rtl/acc_link_chk.sv
module acc_link_chk
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] op,
  input logic [DW-1:0]   dr,
  input logic [IW-1:0]   inpr,
  input logic [DW-1:0]   ac,
  input logic            e
);
  localparam op_vec_t M_AND = op_vec_t'(1) << OP_AND;
  localparam op_vec_t M_ADD = op_vec_t'(1) << OP_ADD;
  localparam op_vec_t M_INP = op_vec_t'(1) << OP_INP;
  localparam op_vec_t M_SHR = op_vec_t'(1) << OP_SHR;
  localparam op_vec_t M_SHL = op_vec_t'(1) << OP_SHL;
  localparam int PADW = DW - IW;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (ac == '0 && e == 1'b0));

  p_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == M_AND) |=> (ac == $past(ac & dr)) && (e == $past(e)));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == M_ADD) |=> ({e, ac} == ($past({1'b0, ac}) + $past({1'b0, dr}))));

  p_rot_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == M_SHR) |=> ({ac, e} == $past({e, ac})));

  p_rot_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == M_SHL) |=> ({e, ac} == $past({ac, e})));

  p_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == M_INP) |=> (ac == {{PADW{1'b0}}, $past(inpr)}) && (e == $past(e)));

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op[OP_CLA] |=> (ac == '0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == '0) |=> ($stable(ac) && $stable(e)));
endmodule

bind acc_link_unit acc_link_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op    (op_i),
  .dr    (dr_i),
  .inpr  (inpr_i),
  .ac    (ac_o),
  .e     (e_o)
);

// File: tb/sim_acc_link_unit.sv
`timescale 1ns/1ps
module sim_acc_link_unit;
  import acc_pkg::*;
  localparam int DW = 16;
  localparam int IW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  op_vec_t       op;
  logic [DW-1:0] dr;
  logic [IW-1:0] inp;
  logic [DW-1:0] ac_o;
  logic          e_o, sign_o, ac_zero_o, e_zero_o;

  acc_link_unit #(.DW(DW), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .dr_i(dr), .inpr_i(inp),
    .ac_o(ac_o), .e_o(e_o), .sign_o(sign_o),
    .ac_zero_o(ac_zero_o), .e_zero_o(e_zero_o)
  );

  typedef struct {
    logic [DW-1:0] ac;
    logic          e;
    string         req;
  } exp_t;

  exp_t          sb[$];
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;
  logic [DW-1:0] m_ac;
  logic          m_e;

  function automatic op_vec_t bit_of(input int b);
    return op_vec_t'(1) << b;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input op_vec_t o, input logic [DW-1:0] d,
                      input logic [IW-1:0] i, input string req);
    logic [DW:0]   s;
    logic [DW-1:0] na;
    logic          ne;
    @(negedge clk);
    op = o; dr = d; inp = i;
    s  = {1'b0, m_ac} + {1'b0, d};
    na = m_ac;
    ne = m_e;
    if (o[OP_CLA])       na = '0;
    else if (o[OP_AND])  na = m_ac & d;
    else if (o[OP_ADD])  begin na = s[DW-1:0]; ne = s[DW]; end
    else if (o[OP_LDDR]) na = d;
    else if (o[OP_INP])  na = {{(DW-IW){1'b0}}, i};
    else if (o[OP_CMA])  na = ~m_ac;
    else if (o[OP_SHR])  begin na = {m_e, m_ac[DW-1:1]}; ne = m_ac[0]; end
    else if (o[OP_SHL])  begin na = {m_ac[DW-2:0], m_e}; ne = m_ac[DW-1]; end
    else if (o[OP_INC])  na = m_ac + 16'd1;
    if (o[OP_CLE])       ne = 1'b0;
    else if (o[OP_CME])  ne = ~m_e;
    sb.push_back('{ac: na, e: ne, req: req});
    m_ac = na;
    m_e  = ne;
  endtask

  // Monitor: compares each queued item one time unit after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (ac_o !== x.ac || e_o !== x.e) begin
          failures++;
          $display("FAIL %s: ac=%h e=%b expected ac=%h e=%b", x.req, ac_o, e_o, x.ac, x.e);
        end
        checks++;
        if (sign_o !== x.ac[DW-1] || ac_zero_o !== (x.ac == '0) || e_zero_o !== ~x.e) begin
          failures++;
          $display("FAIL R11: flags sign=%b z=%b ez=%b expected %b %b %b",
                   sign_o, ac_zero_o, e_zero_o, x.ac[DW-1], (x.ac == '0), ~x.e);
        end
      end
    end
  end

  task automatic check_zero(input string req);
    checks++;
    if (ac_o !== '0 || e_o !== 1'b0) begin
      failures++;
      $display("FAIL %s: ac=%h e=%b expected ac=0000 e=0", req, ac_o, e_o);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; op = '0; dr = '0; inp = '0;
    m_ac = '0; m_e = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_zero("R1 reset");
    rst_n = 1'b1;

    step(bit_of(OP_LDDR), 16'h1234, 8'h00, "R7 load");
    step(bit_of(OP_AND),  16'h0F0F, 8'h00, "R2 and");
    step(bit_of(OP_LDDR), 16'hFFFF, 8'h00, "R7 load");
    step(bit_of(OP_ADD),  16'h0001, 8'h00, "R3 add carry to zero");
    step(bit_of(OP_ADD),  16'h7FFF, 8'h00, "R3 add no carry");
    step(bit_of(OP_ADD),  16'h8001, 8'h00, "R3 add exact carry");
    step(bit_of(OP_SHR),  16'h0000, 8'h00, "R4 rotate right");
    step(bit_of(OP_SHR),  16'h0000, 8'h00, "R4 rotate right");
    step(bit_of(OP_SHR),  16'hFFFF, 8'h00, "R4 rotate right");
    step(bit_of(OP_SHL),  16'h0000, 8'h00, "R5 rotate left");
    step(bit_of(OP_SHL),  16'h0000, 8'h00, "R5 rotate left");
    step(bit_of(OP_LDDR), 16'h8000, 8'h00, "R7 load");
    step(bit_of(OP_CLE),  16'h0000, 8'h00, "R8 clear link");
    step(bit_of(OP_SHL),  16'h0000, 8'h00, "R5 rotate left msb out");
    step(bit_of(OP_LDDR), 16'hFFFF, 8'h00, "R7 load");
    step(bit_of(OP_INP),  16'h1111, 8'hA5, "R6 input clears upper byte");
    step(bit_of(OP_CMA),  16'h0000, 8'h00, "R7 complement");
    step(bit_of(OP_INC),  16'h0000, 8'h00, "R7 increment");
    step(bit_of(OP_LDDR), 16'hFFFF, 8'h00, "R7 load");
    step(bit_of(OP_INC),  16'h0000, 8'h00, "R7 increment wrap");
    step(bit_of(OP_CME),  16'h0000, 8'h00, "R8 complement link");
    step(bit_of(OP_CME),  16'h0000, 8'h00, "R8 complement link");
    step(bit_of(OP_CLE) | bit_of(OP_CME), 16'h0, 8'h00, "R8 clear beats complement");
    step(bit_of(OP_LDDR), 16'h5A5A, 8'h00, "R7 load");
    step(bit_of(OP_CLA) | bit_of(OP_INC), 16'h0, 8'h00, "R9 clear beats increment");
    step(bit_of(OP_CMA) | bit_of(OP_INC), 16'h0, 8'h00, "R9 load beats increment");
    step(bit_of(OP_CLA) | bit_of(OP_LDDR), 16'h7777, 8'h00, "R9 clear beats load");
    step(bit_of(OP_LDDR), 16'hC3C3, 8'h00, "R7 load");
    step(bit_of(OP_CLA),  16'h0000, 8'h00, "R9 clear");
    step(bit_of(OP_LDDR), 16'h8421, 8'h00, "R7 load");
    step('0, 16'hFFFF, 8'hFF, "R10 idle hold");
    step('0, 16'h0000, 8'h12, "R10 idle hold");
    for (int k = 0; k < 12; k++) begin
      step(bit_of(OP_ADD), 16'h3001 * (k + 7), 8'h00, "R3 add sweep");
      step(bit_of(k[0] ? OP_SHL : OP_SHR), 16'h0, 8'h00, "R4 R5 rotate sweep");
    end
    step('0, 16'h0, 8'h0, "R10 idle hold");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_zero("R1 async reset mid-run");
    m_ac = '0; m_e = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(bit_of(OP_CME), 16'h0, 8'h0, "R8 after reset");
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule